// File: doc/BRIEF.md
# Asynchronous Serial Port with Control/Status Register

This block is a full-duplex asynchronous serial port with a small register-mapped front end. Software configures it through one 8-bit control/status register and moves characters through a data location. A write to that location loads the transmitter. A read returns the last received character. The port handles 7-bit or 8-bit characters and can add an odd or even parity bit.

The receiver can be switched on and off. It raises a receive interrupt each time a completed character lands in the receive data register. It keeps one sticky error flag that collects parity, framing and overrun faults. One control bit is a software semaphore and has no effect on the hardware.

Bit timing comes from `baud_tick`, a one-cycle strobe that an external divider supplies at `OVS_RATE` times the baud rate (16 by default). Every bit lasts `OVS_RATE` ticks. The receiver confirms the start bit half a bit after the falling edge and then samples every later bit at its centre.

Top module: `uart_csr_core`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x00, the data location (address 1) reads 0x00, `txd` is high and `rx_irq` is low.
- R2: When control bit 0 is 1 and the transmitter is idle, a write to address 1 starts a frame on `txd`. The frame is a low start bit, then the data bits LSB first, then the parity bit if parity is enabled and otherwise a stop bit, then a high stop bit. Each bit lasts `OVS_RATE` ticks. A write made while bit 0 is 0 is ignored and `txd` stays high.
- R3: Control bit 2 selects the character width: 1 gives 8 data bits and 0 gives 7. In 7-bit mode the transmitter sends only bits 0-6 of the written byte, and bit 7 of the received data always reads 0.
- R4: Control bit 3 enables parity in both directions. Control bit 4 picks the parity sense: 1 is even and 0 is odd. The parity is counted over the data bits plus the parity bit.
- R5: When control bit 5 is 1, the receiver accepts a frame of start bit, data bits, optional parity bit and stop bit. It stores the character in the receive data register and sets `rx_irq`. A read of address 1 clears `rx_irq`.
- R6: A received parity bit that does not match the computed parity, or a 0 sampled at the stop bit, sets control bit 7, the error flag.
- R7: If a new character arrives while the previous one is still unread (`rx_irq` still high), the new character replaces it and the error flag is set.
- R8: Writing 1 to bit 7 of address 0 clears the error flag. Writing 0 to bit 7 leaves it unchanged.
- R9: While control bit 5 is 0 the receiver is held in reset and `rx_irq` is low. Bits 0-6 of the receive data register keep their values, bit 7 is cleared, and frames on `rxd` are not received.
- R10: Control bit 6 reads back what was written and has no effect on the port. Control bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of address 1 clears the interrupt) |
| bus_addr | input | ADDR_W | Address: 0 = control/status, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| baud_tick | input | 1 | One-cycle strobe at OVS_RATE times the baud rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, high when idle |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Register effects show up one clock after the write strobe. The bench drives its strobes on falling edges and reads `bus_rdata` combinationally one cycle later.

The transmit start bit begins on the clock edge that takes the write. Each later bit changes only on the `OVS_RATE`-th tick. The bench therefore finds the falling edge of `txd` and samples half a bit period after it, then once every bit period.

A received character, its interrupt and its error flag are posted a few cycles after the stop-bit centre. The bench reads them only after it has driven the whole stop bit and one idle bit period, so every result is already settled when it is checked.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

   localparam int CHAR_W = 8;

   typedef struct packed {
      logic err;       // bit 7: sticky error
      logic sema;      // bit 6: software semaphore
      logic rx_en;     // bit 5
      logic par_even;  // bit 4
      logic par_en;    // bit 3
      logic wide;      // bit 2: 1 = 8-bit characters
      logic rsv;       // bit 1: reads 0
      logic tx_en;     // bit 0
   } ctl_t;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

   // Parity bit that makes the count of ones odd (even=0) or even (even=1)
   function automatic logic calc_parity(input logic [CHAR_W-1:0] d,
                                        input logic wide,
                                        input logic even);
      logic [CHAR_W-1:0] m;
      m = wide ? d : {1'b0, d[CHAR_W-2:0]};
      return even ? (^m) : ~(^m);
   endfunction

endpackage

// File: rtl/uart_csr_tx.sv
module uart_csr_tx
   import uart_csr_pkg::*;
#(
   parameter int OVS_RATE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic [CHAR_W-1:0] data,
   input  logic              wide,
   input  logic              par_en,
   input  logic              par_even,
   output logic              txd,
   output logic              busy
);
   localparam int CW      = $clog2(OVS_RATE);
   localparam int FRAME_W = CHAR_W + 3;
   localparam int NB_W    = $clog2(FRAME_W + 1);
   localparam logic [CW-1:0] LAST_TICK = CW'(OVS_RATE - 1);

   logic [FRAME_W-1:0] frame, shreg;
   logic [CW-1:0]      tcnt;
   logic [NB_W-1:0]    bits_left, frame_len;
   logic               tail_bit;

   always_comb begin
      tail_bit  = par_en ? calc_parity(data, wide, par_even) : 1'b1;
      frame     = '1;
      frame[0]  = 1'b0;
      if (wide) begin
         frame[CHAR_W:1]   = data;
         frame[CHAR_W+1]   = tail_bit;
         frame_len         = NB_W'(FRAME_W);
      end else begin
         frame[CHAR_W-1:1] = data[CHAR_W-2:0];
         frame[CHAR_W]     = tail_bit;
         frame_len         = NB_W'(FRAME_W - 1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg     <= '1;
         tcnt      <= '0;
         bits_left <= '0;
         busy      <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            shreg     <= frame;
            tcnt      <= '0;
            bits_left <= frame_len;
            busy      <= 1'b1;
         end
      end else if (tick) begin
         if (tcnt == LAST_TICK) begin
            tcnt      <= '0;
            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
            bits_left <= bits_left - 1'b1;
            if (bits_left == NB_W'(1)) busy <= 1'b0;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   assign txd = busy ? shreg[0] : 1'b1;

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !txd));
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(txd));

endmodule

// File: rtl/uart_csr_rx.sv
module uart_csr_rx
   import uart_csr_pkg::*;
#(
   parameter int OVS_RATE    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic              rxd,
   input  logic              wide,
   input  logic              par_en,
   input  logic              par_even,
   output logic              done,
   output logic [CHAR_W-1:0] dout,
   output logic              par_err,
   output logic              frm_err
);
   localparam int CW = $clog2(OVS_RATE);
   localparam logic [CW-1:0] LAST_TICK = CW'(OVS_RATE - 1);
   localparam logic [CW-1:0] MID_TICK  = CW'(OVS_RATE / 2 - 1);

   logic rxd_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxd_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], rxd};
         end
         assign rxd_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   rx_state_t         state;
   logic [CW-1:0]     tcnt;
   logic [3:0]        bidx;
   logic [15:0]       shreg;
   logic [3:0]        nbits;
   logic [CHAR_W-1:0] cdata;
   logic              rpar;

   always_comb begin
      nbits = (wide ? 4'(CHAR_W) : 4'(CHAR_W - 1)) + {3'b0, par_en};
      cdata = wide ? shreg[CHAR_W-1:0] : {1'b0, shreg[CHAR_W-2:0]};
      rpar  = wide ? shreg[CHAR_W] : shreg[CHAR_W-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         state   <= RX_IDLE;
         tcnt    <= '0;
         bidx    <= '0;
         shreg   <= '0;
         done    <= 1'b0;
         dout    <= '0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: if (!rxd_s) begin
                  state <= RX_START;
                  tcnt  <= '0;
               end
               RX_START: if (tcnt == MID_TICK) begin
                  tcnt  <= '0;
                  bidx  <= '0;
                  state <= rxd_s ? RX_IDLE : RX_BITS;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
               RX_BITS: if (tcnt == LAST_TICK) begin
                  tcnt <= '0;
                  if (bidx == nbits) begin
                     done    <= 1'b1;
                     dout    <= cdata;
                     frm_err <= !rxd_s;
                     par_err <= par_en && (rpar != calc_parity(cdata, wide, par_even));
                     state   <= RX_IDLE;
                  end else begin
                     shreg[bidx] <= rxd_s;
                     bidx        <= bidx + 1'b1;
                  end
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_clr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (state == RX_IDLE && !done));

endmodule

// File: rtl/uart_csr_regs.sv
module uart_csr_regs
   import uart_csr_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CHAR_W-1:0] bus_wdata,
   output logic [CHAR_W-1:0] bus_rdata,
   input  logic              rx_done,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   output ctl_t              ctl,
   output logic              irq,
   output logic              tx_start
);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(1);

   logic [CHAR_W-1:0] rdr;
   logic wr_ctl, rd_data, set_err;
   ctl_t wv;

   assign wr_ctl   = bus_wr && (bus_addr == A_CTL);
   assign rd_data  = bus_rd && (bus_addr == A_DATA);
   assign tx_start = bus_wr && (bus_addr == A_DATA) && ctl.tx_en;
   assign set_err  = rx_done && (rx_par_err || rx_frm_err || (irq && !rd_data));
   assign wv       = ctl_t'(bus_wdata);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl <= '0;
      end else begin
         if (wr_ctl) begin
            ctl.tx_en    <= wv.tx_en;
            ctl.wide     <= wv.wide;
            ctl.par_en   <= wv.par_en;
            ctl.par_even <= wv.par_even;
            ctl.rx_en    <= wv.rx_en;
            ctl.sema     <= wv.sema;
         end
         if (set_err)                ctl.err <= 1'b1;
         else if (wr_ctl && wv.err)  ctl.err <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdr <= '0;
         irq <= 1'b0;
      end else if (!ctl.rx_en) begin
         rdr[CHAR_W-1] <= 1'b0;
         irq           <= 1'b0;
      end else if (rx_done) begin
         rdr <= rx_data;
         irq <= 1'b1;
      end else if (rd_data) begin
         irq <= 1'b0;
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_CTL:   bus_rdata = ctl;
         A_DATA:  bus_rdata = {rdr[CHAR_W-1] & ctl.wide, rdr[CHAR_W-2:0]};
         default: bus_rdata = '0;
      endcase
   end

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.err && !(wr_ctl && bus_wdata[7])) |=> ctl.err);
   p_irq_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_done) |=> !irq);
   p_rx_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.rx_en |=> !irq);
   p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && irq && !rd_data && ctl.rx_en) |=> (ctl.err && irq));
   p_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_DATA && !ctl.wide) |-> !bus_rdata[7]);

endmodule

// File: rtl/uart_csr_core.sv
module uart_csr_core
   import uart_csr_pkg::*;
#(
   parameter int OVS_RATE    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              baud_tick,
   input  logic              rxd,
   output logic              txd,
   output logic              rx_irq
);
   generate
      if (OVS_RATE < 4 || (OVS_RATE % 2) != 0) begin : g_bad_ovs
         $error("OVS_RATE must be even and at least 4");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0, 2, 3 or 4");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   ctl_t              ctl;
   logic              tx_start, tx_busy;
   logic              rx_done, rx_perr, rx_ferr;
   logic [CHAR_W-1:0] rx_data;

   uart_csr_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_done(rx_done), .rx_data(rx_data),
      .rx_par_err(rx_perr), .rx_frm_err(rx_ferr),
      .ctl(ctl), .irq(rx_irq), .tx_start(tx_start)
   );

   uart_csr_tx #(.OVS_RATE(OVS_RATE)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick),
      .start(tx_start), .data(bus_wdata),
      .wide(ctl.wide), .par_en(ctl.par_en), .par_even(ctl.par_even),
      .txd(txd), .busy(tx_busy)
   );

   uart_csr_rx #(.OVS_RATE(OVS_RATE), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(!ctl.rx_en), .tick(baud_tick),
      .rxd(rxd), .wide(ctl.wide), .par_en(ctl.par_en), .par_even(ctl.par_even),
      .done(rx_done), .dout(rx_data), .par_err(rx_perr), .frm_err(rx_ferr)
   );

endmodule

// File: tb/uart_csr_core_bench.sv
module uart_csr_core_bench;
   localparam int OVS  = 16;
   localparam int TDIV = 4;
   localparam int BIT  = OVS * TDIV;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic baud_tick = 1'b0, rxd = 1'b1, txd, rx_irq;

   int n_chk = 0, n_bad = 0, tdiv_cnt = 0;
   bit finished = 0;

   uart_csr_core u_uart_csr_core (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .baud_tick(baud_tick), .rxd(rxd), .txd(txd), .rx_irq(rx_irq)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      tdiv_cnt  <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
      baud_tick <= (tdiv_cnt == TDIV - 1);
   end

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic bit par_of(logic [7:0] d, bit wide, bit even);
      logic [7:0] m;
      m = wide ? d : {1'b0, d[6:0]};
      return even ? ^m : ~^m;
   endfunction

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d, input bit strobe);
      @(negedge clk); bus_addr = a; bus_rd = strobe;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic rx_send(logic [7:0] d, bit wide, bit pen, bit even,
                          bit bad_par, bit bad_stop);
      int nd = wide ? 8 : 7;
      rxd = 1'b0; repeat (BIT) @(negedge clk);
      for (int i = 0; i < nd; i++) begin
         rxd = d[i]; repeat (BIT) @(negedge clk);
      end
      if (pen) begin
         rxd = par_of(d, wide, even) ^ bad_par; repeat (BIT) @(negedge clk);
      end
      if (bad_stop) begin
         rxd = 1'b0; repeat (BIT * 5 / 8) @(negedge clk);
      end else begin
         rxd = 1'b1; repeat (BIT) @(negedge clk);
      end
      rxd = 1'b1; repeat (BIT) @(negedge clk);
   endtask

   // writes d and checks the serial frame on txd
   task automatic tx_frame(logic [7:0] d, bit wide, bit pen, bit even, string req);
      logic [10:0] f;
      int nb, wait_c, errs;
      f = '1; f[0] = 1'b0;
      if (wide) begin f[8:1] = d; f[9] = pen ? par_of(d, 1, even) : 1'b1; nb = 11; end
      else      begin f[7:1] = d[6:0]; f[8] = pen ? par_of(d, 0, even) : 1'b1; nb = 10; end
      wr(2'd1, d);
      wait_c = 0;
      while (txd && wait_c < 10) begin @(negedge clk); wait_c++; end
      errs = 0;
      repeat (BIT / 2) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         if (txd !== f[i]) errs++;
         if (i < nb - 1) repeat (BIT) @(negedge clk);
      end
      check(req, errs, 0);
      repeat (BIT) @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, d, cfg, d2;
      bit wide, pen, even, bp, bs;
      void'($urandom(32'h5A17));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v, 0); check("R1 ctl", v, 8'h00);
      rd(2'd1, v, 0); check("R1 data", v, 8'h00);
      check("R1 txd", txd, 1); check("R1 irq", rx_irq, 0);

      // R10 semaphore and reserved bit
      wr(2'd0, 8'h42); rd(2'd0, v, 0); check("R10 sema", v, 8'h40);
      check("R10 txd idle", txd, 1);
      wr(2'd0, 8'h00); rd(2'd0, v, 0); check("R10 sema clear", v, 8'h00);

      // R2 transmitter disabled: write ignored
      begin
         int lows = 0;
         wr(2'd1, 8'h00);
         repeat (2 * BIT) begin @(negedge clk); if (!txd) lows++; end
         check("R2 tx disabled", lows, 0);
      end

      // R3 7-bit transmit drops bit 7, odd parity (R4)
      wr(2'd0, 8'h09);
      tx_frame(8'hFF, 0, 1, 0, "R3 tx 7-bit");

      // random frames in both directions
      for (int k = 0; k < 24; k++) begin
         wide = $urandom % 2; pen = $urandom % 2; even = $urandom % 2;
         d    = 8'($urandom);
         bp   = pen && ($urandom % 4 == 0);
         bs   = ($urandom % 8 == 0);
         cfg  = {2'b00, 1'b1, even, pen, wide, 1'b0, 1'b1};
         wr(2'd0, cfg);
         tx_frame(d, wide, pen, even, "R2/R4 tx frame");
         d2 = 8'($urandom);
         rx_send(d2, wide, pen, even, bp, bs);
         check("R5 irq set", rx_irq, 1);
         rd(2'd0, v, 0); check("R6 error flag", v[7], bp | bs);
         rd(2'd1, v, 1);
         check("R3/R5 rx data", v, wide ? d2 : {1'b0, d2[6:0]});
         @(negedge clk);
         check("R5 irq cleared", rx_irq, 0);
         wr(2'd0, cfg | 8'h80);
         rd(2'd0, v, 0); check("R8 clear", v[7], 0);
      end

      // R7 overrun, then R8 write-0 keeps flag
      wr(2'd0, 8'h25);
      rx_send(8'h11, 1, 0, 0, 0, 0);
      rx_send(8'hC3, 1, 0, 0, 0, 0);
      rd(2'd0, v, 0); check("R7 overrun flag", v[7], 1);
      check("R7 irq still set", rx_irq, 1);
      wr(2'd0, 8'h25); rd(2'd0, v, 0); check("R8 write 0 no effect", v[7], 1);
      rd(2'd1, v, 1); check("R7 newest kept", v, 8'hC3);
      wr(2'd0, 8'hA5); rd(2'd0, v, 0); check("R8 write 1 clears", v, 8'h25);

      // R9 disable keeps bits 0-6, clears bit 7 and irq
      rx_send(8'hB6, 1, 0, 0, 0, 0);
      check("R9 irq before disable", rx_irq, 1);
      wr(2'd0, 8'h05);
      @(negedge clk);
      check("R9 irq cleared", rx_irq, 0);
      rd(2'd1, v, 0); check("R9 data kept", v, 8'h36);
      rx_send(8'h0F, 1, 0, 0, 0, 0);
      check("R9 no reception irq", rx_irq, 0);
      rd(2'd1, v, 0); check("R9 no reception data", v, 8'h36);
      rd(2'd0, v, 0); check("R9 no error", v[7], 0);

      // R6 framing error in 7-bit mode, R3 bit 7 reads 0
      wr(2'd0, 8'h21);
      rx_send(8'hFF, 0, 0, 0, 0, 1);
      rd(2'd0, v, 0); check("R6 framing", v[7], 1);
      rd(2'd1, v, 1); check("R3 rx 7-bit", v, 8'h7F);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule